// File: doc/BRIEF.md
# Receive DMA Burst Lane Planner

This block plans the data phases of a single receive DMA burst. During the burst, frame bytes leave a receive FIFO and are written to a host buffer over a 32-bit bus. A start pulse loads four values: the free space left in the host buffer, the number of frame bytes still to deliver, a word-aligned target address and a lane-swap select. The block then presents one data phase per bus word, with a valid/ready handshake. Each phase carries an address, a data word steered into byte lanes, and active-low byte enables.

The enables are trimmed only at the end of the host buffer. If the frame ends first, its tail still goes out as a complete word, and the lanes beyond the frame carry padding with no defined value. The block also keeps a running count of the frame bytes that actually landed in the buffer. When the burst ends, this count equals the exact number of frame bytes delivered, not the number of bytes the bus wrote.

A per-burst phase allowance caps the burst length. The final phase is flagged, and the block goes idle once that phase is accepted.

Top module: `rxb_burst_planner`

## Requirements
- R1: After reset no phase is offered (`ph_valid` low), `fifo_pop` is low and `frame_written` reads 0.
- R2: While at least four bytes of buffer space remain, a phase enables all four lanes (`ph_be_n` = 4'b0000), even when fewer than four frame bytes remain; in that case the phase is the last one.
- R3: When fewer than four buffer bytes remain, the phase enables only that many lanes. `ph_be_n` bit i belongs to lane i, which is data bits [8i+7:8i]. With swap off these are the lowest lanes: with 9 bytes of space the burst is 0000, 0000, 1110.
- R4: With swap on, frame byte k of a word (FIFO bits [8k+7:8k]) is placed on lane 3-k, and partial enables mirror to the top lanes (1 byte gives 0111).
- R5: `ph_last` is high on a phase when the buffer space or the frame bytes left are at most four, or when the phase is the last one the burst allowance permits. After a last phase is accepted, `ph_valid` is low on the next cycle.
- R6: Once a burst ends, `frame_written` equals the sum over all phases of min(frame bytes left, buffer bytes left, 4). This equals the exact number of frame bytes delivered.
- R7: The first phase address is `start_addr` with its two low bits cleared, and each accepted phase advances the address by 4.
- R8: While `ph_ready` is low, the offered phase stays valid and its address, enables and last flag do not change.
- R9: A start pulse is ignored while a burst is in progress, and also when buffer space, frame length or allowance is zero.
- R10: A buffer smaller than four bytes yields a single phase that enables only the valid lanes.
- R11: With swap off, the frame lanes of `ph_data` equal `fifo_data`. `fifo_pop` is high exactly in the cycles in which a phase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new burst |
| buf_space | input | CNT_W | Free bytes in the host buffer |
| frame_len | input | CNT_W | Frame bytes still to deliver |
| start_addr | input | ADDR_W | Target address (low bits ignored) |
| swap_en | input | 1 | Reverse lane order in each word |
| burst_max | input | BURST_W | Maximum phases in this burst |
| fifo_data | input | 8*LANES | Next FIFO word, frame byte k in bits [8k+7:8k] |
| fifo_pop | output | 1 | FIFO word consumed |
| ph_valid | output | 1 | Data phase offered |
| ph_ready | input | 1 | Data phase accepted |
| ph_addr | output | ADDR_W | Phase word address |
| ph_data | output | 8*LANES | Lane-steered data word |
| ph_be_n | output | LANES | Active-low byte enables |
| ph_last | output | 1 | Final phase of the burst |
| frame_written | output | CNT_W | Frame bytes delivered this burst |

## Verification
The assertions assume that `ph_ready` is the only input that controls whether a phase is taken, and that the FIFO always has a word available when a phase is offered. The bench meets these assumptions by presenting a fresh random `fifo_data` word in every cycle and by never gating acceptance on anything else. Start pulses arrive mostly while the block is idle. Deliberate starts during a burst and starts with zero lengths are used only in directed cases that confirm the pulse is dropped. Random lengths stay far below the counter width, so the byte counters never wrap.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   // Active-high lane enables for a word of 'lanes' lanes, given bytes left in the buffer
   function automatic logic [31:0] low_lanes(input int unsigned left, input int unsigned lanes);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < lanes; i++) m[i] = (left > i);
      return m;
   endfunction
endpackage

// File: rtl/rxb_lane_swap.sv
module rxb_lane_swap #(
   parameter int LANES = 4
) (
   input  logic               swap,
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = swap ? din[8*(LANES-1-i) +: 8] : din[8*i +: 8];
   end
endmodule

// File: rtl/rxb_enable_gen.sv
module rxb_enable_gen #(
   parameter int LANES = 4,
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] buf_left,
   input  logic             swap,
   output logic [LANES-1:0] be_n
);
   logic [LANES-1:0] en_low;

   for (genvar i = 0; i < LANES; i++) begin : g_en
      assign en_low[i] = (buf_left > CNT_W'(i));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_mirror
      assign be_n[i] = ~(swap ? en_low[LANES-1-i] : en_low[i]);
   end
endmodule

// File: rtl/rxb_phase_track.sv
module rxb_phase_track #(
   parameter int LANES   = 4,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 32,
   parameter int BURST_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   buf_space,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic               swap_en,
   input  logic [BURST_W-1:0] burst_max,
   input  logic               accept,
   output logic               active,
   output logic [CNT_W-1:0]   buf_left,
   output logic [CNT_W-1:0]   frm_left,
   output logic [ADDR_W-1:0]  addr,
   output logic               swap_q,
   output logic               last,
   output logic [CNT_W-1:0]   written
);
   localparam int LB = $clog2(LANES);
   localparam logic [CNT_W-1:0]  WORD_BYTES = CNT_W'(LANES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << LB) - 1);

   logic [BURST_W-1:0] phases_left;
   logic [CNT_W-1:0]   step_bytes;
   logic               load_ok;

   assign load_ok = start && !active && (buf_space != '0) && (frame_len != '0) && (burst_max != '0);
   assign last    = (buf_left <= WORD_BYTES) || (frm_left <= WORD_BYTES) || (phases_left == BURST_W'(1));

   always_comb begin
      step_bytes = WORD_BYTES;
      if (frm_left < step_bytes) step_bytes = frm_left;
      if (buf_left < step_bytes) step_bytes = buf_left;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active      <= 1'b0;
         buf_left    <= '0;
         frm_left    <= '0;
         addr        <= '0;
         swap_q      <= 1'b0;
         phases_left <= '0;
         written     <= '0;
      end else if (load_ok) begin
         active      <= 1'b1;
         buf_left    <= buf_space;
         frm_left    <= frame_len;
         addr        <= start_addr & ALIGN_MASK;
         swap_q      <= swap_en;
         phases_left <= burst_max;
         written     <= '0;
      end else if (accept) begin
         buf_left    <= buf_left - WORD_BYTES;
         frm_left    <= frm_left - WORD_BYTES;
         addr        <= addr + ADDR_W'(LANES);
         phases_left <= phases_left - BURST_W'(1);
         written     <= written + step_bytes;
         if (last) active <= 1'b0;
      end
   end
endmodule

// File: rtl/rxb_burst_planner.sv
module rxb_burst_planner #(
   parameter int LANES   = 4,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 32,
   parameter int BURST_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   buf_space,
   input  logic [CNT_W-1:0]   frame_len,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic               swap_en,
   input  logic [BURST_W-1:0] burst_max,
   input  logic [8*LANES-1:0] fifo_data,
   output logic               fifo_pop,
   output logic               ph_valid,
   input  logic               ph_ready,
   output logic [ADDR_W-1:0]  ph_addr,
   output logic [8*LANES-1:0] ph_data,
   output logic [LANES-1:0]   ph_be_n,
   output logic               ph_last,
   output logic [CNT_W-1:0]   frame_written
);
   localparam int LB = $clog2(LANES);

   if ((LANES < 2) || ((1 << LB) != LANES)) begin : g_bad_lanes
      $error("LANES must be a power of two and at least 2");
   end
   if (CNT_W <= LB + 1) begin : g_bad_cnt
      $error("CNT_W too narrow for LANES");
   end
   if (ADDR_W <= LB) begin : g_bad_addr
      $error("ADDR_W too narrow for LANES");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be positive");
   end

   logic             active, swap_q, accept;
   logic [CNT_W-1:0] buf_left, frm_left;

   assign accept   = active && ph_ready;
   assign ph_valid = active;
   assign fifo_pop = accept;

   rxb_phase_track #(.LANES(LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_track (
      .clk(clk), .rst_n(rst_n), .start(start), .buf_space(buf_space), .frame_len(frame_len),
      .start_addr(start_addr), .swap_en(swap_en), .burst_max(burst_max), .accept(accept),
      .active(active), .buf_left(buf_left), .frm_left(frm_left), .addr(ph_addr),
      .swap_q(swap_q), .last(ph_last), .written(frame_written)
   );

   rxb_enable_gen #(.LANES(LANES), .CNT_W(CNT_W)) u_en (
      .buf_left(buf_left), .swap(swap_q), .be_n(ph_be_n)
   );

   rxb_lane_swap #(.LANES(LANES)) u_swap (
      .swap(swap_q), .din(fifo_data), .dout(ph_data)
   );
endmodule

// File: rtl/rxb_burst_planner_chk.sv
module rxb_burst_planner_chk #(
   parameter int LANES  = 4,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ph_valid,
   input logic              ph_ready,
   input logic              ph_last,
   input logic [LANES-1:0]  ph_be_n,
   input logic [ADDR_W-1:0] ph_addr,
   input logic              fifo_pop,
   input logic [CNT_W-1:0]  frame_written
);
   function automatic logic contiguous(input logic [LANES-1:0] be_n);
      logic [LANES-1:0] en, dis;
      en  = ~be_n;
      dis = be_n;
      return (en != '0) && (((en & (en + LANES'(1))) == '0) || ((dis & (dis + LANES'(1))) == '0));
   endfunction

   // R2
   nonlast_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid && !ph_last |-> ph_be_n == '0);
   // R3
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid |-> contiguous(ph_be_n));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid && !ph_ready |=> ph_valid && $stable(ph_be_n) && $stable(ph_addr) && $stable(ph_last));
   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid && ph_ready && !ph_last |=> ph_addr == $past(ph_addr) + ADDR_W'(LANES));
   // R5
   end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid && ph_ready && ph_last |=> !ph_valid);
   // R11
   pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> ph_valid);
   // R6
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_valid && $past(!ph_valid) |-> $stable(frame_written));
endmodule

bind rxb_burst_planner rxb_burst_planner_chk #(.LANES(LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_last(ph_last),
   .ph_be_n(ph_be_n), .ph_addr(ph_addr), .fifo_pop(fifo_pop), .frame_written(frame_written)
);

// File: tb/test_rxb_burst_planner.sv
`timescale 1ns/1ps
module test_rxb_burst_planner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] buf_space = '0, frame_len = '0;
   logic [31:0] start_addr = '0;
   logic        swap_en = 1'b0;
   logic [7:0]  burst_max = '0;
   logic [31:0] fifo_data = '0;
   logic        fifo_pop, ph_valid, ph_last;
   logic        ph_ready = 1'b0;
   logic [31:0] ph_addr, ph_data;
   logic [3:0]  ph_be_n;
   logic [15:0] frame_written;

   int n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;

   rxb_burst_planner i_rxb_burst_planner (
      .clk(clk), .rst_n(rst_n), .start(start), .buf_space(buf_space), .frame_len(frame_len),
      .start_addr(start_addr), .swap_en(swap_en), .burst_max(burst_max), .fifo_data(fifo_data),
      .fifo_pop(fifo_pop), .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_addr(ph_addr),
      .ph_data(ph_data), .ph_be_n(ph_be_n), .ph_last(ph_last), .frame_written(frame_written)
   );

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input int left, input bit sw);
      logic [3:0] en;
      for (int i = 0; i < 4; i++) en[i] = (left > i);
      if (sw) en = {en[0], en[1], en[2], en[3]};
      return ~en;
   endfunction

   function automatic int min3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      return m;
   endfunction

   // Runs one burst and compares every phase against the model
   task automatic run_burst(input int bs, input int fl, input logic [31:0] ad, input bit sw,
                            input int bm, input bit rdy_rand, input bit poke, input string tag);
      int k, exp_cnt, guard, brem, frem, nb;
      bit done, poked;
      logic [3:0] ebe;
      bit elast;
      @(negedge clk);
      start = 1'b1; buf_space = 16'(bs); frame_len = 16'(fl);
      start_addr = ad; swap_en = sw; burst_max = 8'(bm);
      @(negedge clk);
      start = 1'b0;
      k = 0; exp_cnt = 0; guard = 0; done = 0; poked = 0;
      while (!done && guard < 2000) begin
         guard++;
         ph_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
         fifo_data = $urandom;
         start = 1'b0;
         if (poke && k == 1 && !poked) begin
            // R9: start during a burst with other values must be ignored
            poked = 1; ph_ready = 1'b0; start = 1'b1;
            buf_space = 16'd4; frame_len = 16'd4; start_addr = 32'hFFFF_0000; swap_en = ~sw; burst_max = 8'd1;
         end
         #1;
         brem = bs - 4 * k; frem = fl - 4 * k;
         ebe = exp_be(brem, sw);
         elast = (brem <= 4) || (frem <= 4) || (k == bm - 1);
         nb = min3(brem, frem, 4);
         chk(ph_valid == 1'b1, "R5", {tag, " valid during burst"}, ph_valid, 1);
         chk(ph_be_n == ebe, (brem >= 4) ? "R2" : (sw ? "R4" : "R3"), {tag, " byte enables"}, ph_be_n, ebe);
         chk(ph_last == elast, "R5", {tag, " last flag"}, ph_last, elast);
         chk(ph_addr == ((ad & ~32'h3) + 32'(4 * k)), "R7", {tag, " address"}, ph_addr, (ad & ~32'h3) + 32'(4 * k));
         for (int j = 0; j < nb; j++) begin
            int ln;
            ln = sw ? 3 - j : j;
            chk(ph_data[8*ln +: 8] == fifo_data[8*j +: 8], sw ? "R4" : "R11", {tag, " data lane"},
                ph_data[8*ln +: 8], fifo_data[8*j +: 8]);
         end
         chk(fifo_pop == ph_ready, "R11", {tag, " pop"}, fifo_pop, ph_ready);
         @(negedge clk);
         if (ph_ready) begin
            exp_cnt += nb;
            k++;
            if (elast) done = 1;
         end
      end
      start = 1'b0; ph_ready = 1'b0;
      #1;
      chk(ph_valid == 1'b0, "R5", {tag, " idle after last"}, ph_valid, 0);
      chk(frame_written == 16'(exp_cnt), "R6", {tag, " frame bytes written"}, frame_written, exp_cnt);
      if (bs < 4) chk(k == 1, "R10", {tag, " single phase"}, k, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int keep;
      repeat (3) @(negedge clk);
      #1;
      chk(ph_valid == 1'b0, "R1", "valid in reset", ph_valid, 0);
      chk(fifo_pop == 1'b0, "R1", "pop in reset", fifo_pop, 0);
      chk(frame_written == 16'd0, "R1", "count in reset", frame_written, 0);
      @(negedge clk); rst_n = 1'b1;

      run_burst(9, 100, 32'h1000, 0, 16, 0, 0, "R3 nine bytes");
      run_burst(9, 100, 32'h2004, 1, 16, 0, 0, "R4 nine swapped");
      run_burst(20, 1, 32'h3000, 0, 16, 0, 0, "R2 one frame byte");
      run_burst(20, 6, 32'h3103, 1, 16, 1, 0, "R2 tail padding");
      run_burst(3, 50, 32'h4000, 0, 16, 0, 0, "R10 three bytes");
      run_burst(2, 50, 32'h4000, 1, 16, 0, 0, "R10 two swapped");
      run_burst(200, 200, 32'h5000, 0, 2, 1, 0, "R5 allowance");
      run_burst(40, 40, 32'h6000, 0, 32, 1, 1, "R9 busy start");

      // R9: zero lengths do not start a burst
      keep = frame_written;
      for (int z = 0; z < 3; z++) begin
         @(negedge clk);
         start = 1'b1; buf_space = (z == 0) ? 16'd0 : 16'd8;
         frame_len = (z == 1) ? 16'd0 : 16'd8; burst_max = (z == 2) ? 8'd0 : 8'd4;
         @(negedge clk);
         start = 1'b0;
         #1;
         chk(ph_valid == 1'b0, "R9", "zero length start", ph_valid, 0);
         chk(frame_written == 16'(keep), "R9", "count after ignored start", frame_written, keep);
      end

      for (int r = 0; r < 40; r++) begin
         run_burst(1 + $urandom % 90, 1 + $urandom % 90, $urandom, $urandom % 2,
                   1 + $urandom % 30, 1, 0, "random");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end
endmodule